// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block maps a 32-bit system address onto one of two memory channels and one of four ranks in that channel. Software sets a bank of eight byte-wide boundary registers, four per channel. Each register holds a running total: the combined size of its own rank and every lower rank in the same channel, counted in 32 MB units. When a rank is empty, its register repeats the value below it, so that rank never matches any address. The bit of weight 128 is allowed only in the top rank of a channel. It stands for exactly 128 units, which makes the whole 4 GB space populated.

There are two modes. In single-channel mode, channel A serves every address and the channel B registers have no effect. In interleaved mode, consecutive 64-byte lines alternate between the channels. Each boundary unit then covers 64 MB of system space, and the two channels must be programmed with identical values. The decode result and a configuration-error flag are registered and appear one clock after the address is presented.

Top module: `rkmap_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every boundary register reads 00h and dec_hit, dec_oor, dec_chan, dec_rank and cfg_err are all 0.
- R2: A write with cfg_we=1 stores cfg_wdata into the register chosen by cfg_sel, where cfg_sel[2] is the channel (0 = A, 1 = B) and cfg_sel[1:0] is the rank. cfg_rdata shows the chosen register combinationally.
- R3: In single-channel mode (interleave=0) the address unit is sys_addr[31:25]. The decoded rank is the lowest-numbered rank whose boundary is strictly greater than that unit, and dec_hit=1.
- R4: A rank whose boundary equals the boundary of the rank below it is never decoded.
- R5: If the unit is at or above the top boundary, dec_oor=1, dec_hit=0 and dec_rank=0. Outside reset, exactly one of dec_hit and dec_oor is 1.
- R6: In interleaved mode (interleave=1) the unit is sys_addr[31:26], dec_chan equals sys_addr[6], and that channel's registers are used.
- R7: In single-channel mode dec_chan=0, and the channel B registers affect neither the decode nor cfg_err.
- R8: A boundary with bit 7 set counts as 128 units, so with it in rank 3 every address hits.
- R9: cfg_err=1 when any register in use has a nonzero bit 1 or bit 0, when rank 0, 1 or 2 has bit 7 set, or, in interleaved mode, when the two channels differ at any rank. "In use" means channel A only in single-channel mode, and both channels in interleaved mode.
- R10: The decode outputs reflect the sys_addr and interleave values of the previous cycle. A register written at one clock edge is used by the decode at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select {channel, rank} |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of selected register |
| interleave | input | 1 | 1 = two-channel interleaved, 0 = single channel |
| sys_addr | input | 32 | System address to decode |
| dec_chan | output | 1 | Decoded channel |
| dec_rank | output | 2 | Decoded rank |
| dec_hit | output | 1 | Address falls inside a populated rank |
| dec_oor | output | 1 | Address at or above top boundary |
| cfg_err | output | 1 | Boundary programming violates the rules |

## Verification
The assertions run on every cycle and check four things: dec_hit and dec_oor exclude each other, the channel rules of both modes hold, a full top boundary forces a hit, and a write shows up on read-back. Picking the correct lowest rank, skipping empty ranks, the exact out-of-range edge at each boundary, the interleaved unit scaling and every cause of a configuration error all depend on particular register contents. The bench's scenarios cover these and compare each result against an independent model.

// File: rtl/rkmap_pkg.sv
package rkmap_pkg;
  localparam int NCH       = 2;
  localparam int NRK       = 4;
  localparam int BW        = 8;
  localparam int AW        = 32;
  localparam int RKW       = $clog2(NRK);
  localparam int SELW      = RKW + $clog2(NCH);
  localparam int UNIT_LSB  = 25;   // 32 MB unit in single-channel mode
  localparam int LINE_BIT  = 6;    // 64-byte interleave granularity
  localparam int UW        = AW - UNIT_LSB + 1;

  typedef logic [BW-1:0] bnd_t;
  typedef bnd_t [NRK-1:0] chan_bnd_t;

  // Effective boundary in units; top bit means a full 128 units.
  function automatic logic [UW-1:0] eff_bnd(input bnd_t b);
    logic [UW-1:0] r;
    if (b[BW-1]) r = UW'(128);
    else         r = UW'(b[BW-2:0]);
    return r;
  endfunction

  // Address expressed in boundary units; a unit spans twice as much when interleaved.
  function automatic logic [UW-1:0] addr_unit(input logic [AW-1:0] a, input logic il);
    logic [UW-1:0] u;
    if (il) u = UW'(a[AW-1:UNIT_LSB+1]);
    else    u = UW'(a[AW-1:UNIT_LSB]);
    return u;
  endfunction

  // Rule check for one register at a given rank position.
  function automatic logic bnd_bad(input bnd_t b, input int unsigned rank);
    return (b[1:0] != 2'b00) || (b[BW-1] && (rank != NRK - 1));
  endfunction
endpackage

// File: rtl/rkmap_regbank.sv
module rkmap_regbank
  import rkmap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] sel,
  input  bnd_t            wdata,
  output bnd_t            rdata,
  output chan_bnd_t       bnd_o [NCH]
);
  bnd_t regs_q [NCH][NRK];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    for (genvar r = 0; r < NRK; r++) begin : g_rk
      always_ff @(posedge clk) begin
        if (!rst_n)
          regs_q[c][r] <= '0;
        else if (we && sel == SELW'(c * NRK + r))
          regs_q[c][r] <= wdata;
      end
      assign bnd_o[c][r] = regs_q[c][r];
    end
  end

  assign rdata = regs_q[sel[SELW-1:RKW]][sel[RKW-1:0]];
endmodule

// File: rtl/rkmap_lookup.sv
module rkmap_lookup
  import rkmap_pkg::*;
(
  input  chan_bnd_t          bnd,
  input  logic [UW-1:0]      unit,
  output logic               hit,
  output logic [RKW-1:0]     rank
);
  logic [NRK-1:0] above;

  for (genvar r = 0; r < NRK; r++) begin : g_cmp
    assign above[r] = eff_bnd(bnd[r]) > unit;
  end

  always_comb begin
    hit  = 1'b0;
    rank = '0;
    for (int r = NRK - 1; r >= 0; r--) begin
      if (above[r]) begin
        hit  = 1'b1;
        rank = RKW'(r);
      end
    end
  end
endmodule

// File: rtl/rkmap_cfgcheck.sv
module rkmap_cfgcheck
  import rkmap_pkg::*;
(
  input  chan_bnd_t bnd [NCH],
  input  logic      il,
  output logic      err
);
  logic [NCH-1:0] ch_bad;
  logic [NRK-1:0] mismatch;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NRK-1:0] rk_bad;
    for (genvar r = 0; r < NRK; r++) begin : g_rk
      assign rk_bad[r] = bnd_bad(bnd[c][r], r);
    end
    assign ch_bad[c] = |rk_bad;
  end

  for (genvar r = 0; r < NRK; r++) begin : g_mm
    assign mismatch[r] = bnd[0][r] != bnd[NCH-1][r];
  end

  assign err = il ? ((|ch_bad) || (|mismatch)) : ch_bad[0];
endmodule

// File: rtl/rkmap_top.sv
module rkmap_top
  import rkmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SELW-1:0]      cfg_sel,
  input  logic [BW-1:0]        cfg_wdata,
  output logic [BW-1:0]        cfg_rdata,
  input  logic                 interleave,
  input  logic [AW-1:0]        sys_addr,
  output logic                 dec_chan,
  output logic [RKW-1:0]       dec_rank,
  output logic                 dec_hit,
  output logic                 dec_oor,
  output logic                 cfg_err
);
  chan_bnd_t       bnd [NCH];
  logic            chan_w;
  logic [UW-1:0]   unit_w;
  logic            hit_w;
  logic [RKW-1:0]  rank_w;
  logic            err_w;
  logic            top_full_w;   // selected channel's top rank spans 4 GB

  rkmap_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .bnd_o(bnd)
  );

  assign chan_w     = interleave & sys_addr[LINE_BIT];
  assign unit_w     = addr_unit(sys_addr, interleave);
  assign top_full_w = bnd[chan_w][NRK-1][BW-1];

  rkmap_lookup u_lookup (
    .bnd(bnd[chan_w]), .unit(unit_w), .hit(hit_w), .rank(rank_w)
  );

  rkmap_cfgcheck u_cfgchk (
    .bnd(bnd), .il(interleave), .err(err_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_chan <= 1'b0;
      dec_rank <= '0;
      dec_hit  <= 1'b0;
      dec_oor  <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      dec_chan <= chan_w;
      dec_rank <= hit_w ? rank_w : '0;
      dec_hit  <= hit_w;
      dec_oor  <= !hit_w;
      cfg_err  <= err_w;
    end
  end
endmodule

// File: rtl/rkmap_chk.sv
module rkmap_chk
  import rkmap_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [SELW-1:0] cfg_sel,
  input logic [BW-1:0]   cfg_wdata,
  input logic [BW-1:0]   cfg_rdata,
  input logic            interleave,
  input logic [AW-1:0]   sys_addr,
  input logic            dec_chan,
  input logic [RKW-1:0]  dec_rank,
  input logic            dec_hit,
  input logic            dec_oor,
  input logic            top_full_w
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_hit_xor_oor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (dec_hit != dec_oor));

  assert_oor_rank_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_oor |-> (dec_rank == '0));

  assert_single_chan_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(interleave)) |-> !dec_chan);

  assert_il_chan_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(interleave)) |-> (dec_chan == $past(sys_addr[LINE_BIT])));

  assert_full_top_hits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(top_full_w)) |-> dec_hit);

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_we) && $stable(cfg_sel)) |-> (cfg_rdata == $past(cfg_wdata)));
endmodule

bind rkmap_top rkmap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .interleave(interleave),
  .sys_addr(sys_addr), .dec_chan(dec_chan), .dec_rank(dec_rank),
  .dec_hit(dec_hit), .dec_oor(dec_oor), .top_full_w(top_full_w)
);

// File: tb/rkmap_top_tb.sv
module rkmap_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        interleave = 1'b0;
  logic [31:0] sys_addr = '0;
  logic        dec_chan;
  logic [1:0]  dec_rank;
  logic        dec_hit;
  logic        dec_oor;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       chan;
    logic [1:0] rank;
    logic       hit;
    logic       err;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  logic [7:0] mdl [2][4];

  always #5 clk = ~clk;

  rkmap_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .interleave(interleave),
    .sys_addr(sys_addr), .dec_chan(dec_chan), .dec_rank(dec_rank),
    .dec_hit(dec_hit), .dec_oor(dec_oor), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] a, input logic il, input string tag);
    exp_t e;
    int u, ch, lim, nch;
    e.chan = 1'b0; e.rank = 2'd0; e.hit = 1'b0; e.err = 1'b0; e.tag = tag;
    u  = il ? int'(a >> 26) : int'(a >> 25);
    ch = il ? int'(a[6]) : 0;
    e.chan = ch[0];
    for (int r = 0; r < 4; r++) begin
      lim = mdl[ch][r][7] ? 128 : int'(mdl[ch][r] & 8'h7f);
      if (!e.hit && lim > u) begin
        e.hit = 1'b1;
        e.rank = r[1:0];
      end
    end
    nch = il ? 2 : 1;
    for (int c = 0; c < nch; c++)
      for (int r = 0; r < 4; r++)
        if ((mdl[c][r] & 8'h03) != 0 || (r < 3 && mdl[c][r][7])) e.err = 1'b1;
    if (il)
      for (int r = 0; r < 4; r++)
        if (mdl[0][r] != mdl[1][r]) e.err = 1'b1;
    return e;
  endfunction

  task automatic wr(input int c, input int r, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {c[0], r[1:0]}; cfg_wdata = d;
    mdl[c][r] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic dec(input logic [31:0] a, input logic il, input string tag);
    @(negedge clk);
    sys_addr = a; interleave = il;
    sb_q.push_back(model(a, il, tag));
  endtask

  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check({e.tag, " hit"},  int'(dec_hit),  int'(e.hit));
      check({e.tag, " oor"},  int'(dec_oor),  int'(!e.hit));
      check({e.tag, " chan"}, int'(dec_chan), int'(e.chan));
      check({e.tag, " rank"}, int'(dec_rank), int'(e.rank));
      check({e.tag, " err"},  int'(cfg_err),  int'(e.err));
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) for (int r = 0; r < 4; r++) mdl[c][r] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 hit", int'(dec_hit), 0);
    check("R1 oor", int'(dec_oor), 0);
    check("R1 err", int'(cfg_err), 0);
    check("R1 rdata", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    #1 check("R1 post-reset hit", int'(dec_hit), 0);
    dec(32'h0000_0000, 1'b0, "R5 empty map");

    // Channel A: 128 MB, empty, 256 MB, 128 MB
    wr(0, 0, 8'h04); wr(0, 1, 8'h04); wr(0, 2, 8'h0C); wr(0, 3, 8'h10);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk); cfg_sel = {1'b0, r[1:0]};
      #1 check("R2 readback", int'(cfg_rdata), int'(mdl[0][r]));
    end
    dec(32'h0000_0000, 1'b0, "R3 rank0 low");
    dec(32'h07FF_FFFF, 1'b0, "R3 rank0 top");
    dec(32'h0800_0000, 1'b0, "R4 skip empty");
    dec(32'h17FF_FFFF, 1'b0, "R3 rank2 top");
    dec(32'h1800_0000, 1'b0, "R3 rank3");
    dec(32'h2000_0000, 1'b0, "R5 at top");
    dec(32'hFFFF_FFFF, 1'b0, "R5 max");

    // R7: channel B garbage ignored in single mode
    wr(1, 0, 8'h03); wr(1, 3, 8'h81);
    dec(32'h0000_0040, 1'b0, "R7 single chanA");
    dec(32'h1800_0040, 1'b0, "R7 no err");

    // R6: interleaved with matching channels
    wr(1, 0, 8'h04); wr(1, 1, 8'h04); wr(1, 2, 8'h0C); wr(1, 3, 8'h10);
    dec(32'h0000_0040, 1'b1, "R6 chan1 rank0");
    dec(32'h0FFF_FFBF, 1'b1, "R6 chan0 rank0 top");
    dec(32'h1000_0000, 1'b1, "R6 skip empty");
    dec(32'h3FFF_FFFF, 1'b1, "R6 chan1 rank3");
    dec(32'h4000_0000, 1'b1, "R6 oor");
    // R9: mismatch between channels
    wr(1, 2, 8'h08);
    dec(32'h0000_0000, 1'b1, "R9 mismatch");
    dec(32'h0000_0000, 1'b0, "R9 mismatch single");
    wr(1, 2, 8'h0C);

    // R8: full 4 GB top rank
    wr(0, 3, 8'h80); wr(1, 3, 8'h80);
    dec(32'hFFFF_FFC0, 1'b1, "R8 il full");
    dec(32'hFFFF_FFFF, 1'b0, "R8 single full");

    // R9: low bits and bit7 misuse
    wr(0, 0, 8'h05);
    dec(32'h0000_0000, 1'b0, "R9 low bits");
    wr(0, 0, 8'h04); wr(0, 1, 8'h84);
    dec(32'h0000_0000, 1'b0, "R9 bit7 low rank");
    wr(0, 1, 8'h04);

    // R10: write used by decode of following cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'b000; cfg_wdata = 8'h00; mdl[0][0] = 8'h00;
    sys_addr = 32'h0000_0000; interleave = 1'b0;
    sb_q.push_back(model(32'h0000_0000, 1'b0, "R10 same cycle"));
    mdl[0][0] = 8'h04;   // decode at this edge still sees old value
    sb_q[0] = model(32'h0000_0000, 1'b0, "R10 same cycle");
    mdl[0][0] = 8'h00;
    @(negedge clk);
    cfg_we = 1'b0;
    sb_q.push_back(model(32'h0000_0000, 1'b0, "R10 next cycle"));

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule